// File: doc/BRIEF.md
# Prebias-Safe Gate Enable and Bootstrap Refresh Logic

This block sits between the PWM comparator and the two gate drivers of a synchronous buck power stage. Every input is sampled on the controller clock. The inputs are the raw PWM level, a run flag from the start-up and fault sequencer, and a one-cycle strobe that marks each half of an oscillator period. The block produces two gate commands, one for the upper switch and one for the lower switch. While both commands are low, the switch node floats. This lets the converter start into an output that already holds a voltage without pulling that voltage down.

After each start, switching stays off until the PWM input has produced two pulses. Those pulses show that the control loop has become linear. The block then turns on the lower switch first so that the bootstrap capacitor is charged before the upper switch is first driven. From that point every duty cycle from 0% to 100% passes through unclamped. Between the two gates there is a one-clock break-before-make gap. A long run at full duty leaves the bootstrap capacitor without a recharge path, so after a programmable number of oscillator periods at full duty the block inserts a short lower-switch pulse of about half a period.

Top module: `prebias_gate_ctrl`

## Requirements
- R1: During reset and after it is released, with run_i low, hs_o and ls_o are both 0.
- R2: With run_i high, both outputs stay 0 until run_i has been high while pwm_i rose twice. A rise is pwm_i sampled 1 when it was sampled 0 on the previous clock. After the first rise the outputs are still 0.
- R3: When the second rise is sampled at clock edge e, ls_o goes to 1 after edge e+2 and stays 1 for one clock. hs_o stays 0 until after edge e+4 and then follows pwm_i.
- R4: hs_o and ls_o are never 1 in the same cycle. A gate turns on only when the opposite gate was 0 in both the current and the previous cycle.
- R5: While switching, a PWM high pulse that lasts W clocks (W at least 2) gives an hs_o pulse of W-1 clocks. ls_o is then 0 for W+1 clocks.
- R6: While switching, pwm_i held at 0 keeps ls_o at 1 continuously. pwm_i held at 1 keeps hs_o at 1 continuously, as long as the run is shorter than the refresh limit.
- R7: After 2*REFRESH_PERIODS half-period strobes in a row with pwm_i high, the block drops hs_o and then raises ls_o until the next strobe. It then returns to driving hs_o.
- R8: Any cycle with pwm_i low restarts the full-duty count. Each refresh pulse also restarts it.
- R9: When run_i is sampled low, both outputs are 0 after that same clock edge. They stay 0 while run_i remains low.
- R10: PWM rises that occur while run_i is low do not count toward arming. Every restart needs two new rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 1 | Raw PWM comparator output |
| run_i | input | 1 | Run flag from the sequencer; low means disable or fault |
| half_i | input | 1 | One-cycle strobe at each oscillator half period |
| hs_o | output | 1 | Upper gate command |
| ls_o | output | 1 | Lower gate command |

## Verification
The bench checks the exact cycle of the first lower-gate pulse after the second PWM rise. A design that armed on the first rise, or that drove the upper gate first, would show an output too early or show hs_o ahead of ls_o. The bench measures pulse widths at the narrowest PWM pulse and at held 0% and 100% duty. This catches a missing dead-time gap, which would give an overlap or wrong widths, and catches duty clamping. The refresh timing is checked against a strobe count. A PWM dip just short of the limit must suppress the refresh, which exposes a counter that does not clear on low PWM. Disable and restart cases confirm that pulses seen while run_i is low never arm the block.

// File: rtl/gate_ctrl_pkg.sv
package gate_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_PRIME  = 2'd1,
    ST_SWITCH = 2'd2
  } gate_state_e;
endpackage

// File: rtl/gate_arm_qual.sv
module gate_arm_qual #(
  parameter int unsigned ARM_PULSES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  input  logic run_i,
  output logic armed_o
);
  localparam int unsigned CW = $clog2(ARM_PULSES + 1);

  logic          pwm_d;
  logic [CW-1:0] cnt_q;
  logic          rise;

  assign rise    = pwm_i & ~pwm_d;
  assign armed_o = (cnt_q == CW'(ARM_PULSES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_d <= 1'b0;
      cnt_q <= '0;
    end else begin
      pwm_d <= pwm_i;
      if (!run_i)
        cnt_q <= '0;
      else if (rise && !armed_o)
        cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/gate_refresh_watch.sv
module gate_refresh_watch #(
  parameter int unsigned REFRESH_PERIODS = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic pwm_i,
  input  logic half_i,
  output logic refresh_o
);
  localparam int unsigned LIMIT = 2 * REFRESH_PERIODS;
  localparam int unsigned CW    = $clog2(LIMIT);

  logic [CW-1:0] cnt_q;
  logic          refresh_q;

  assign refresh_o = refresh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      refresh_q <= 1'b0;
    end else if (!active_i || !pwm_i) begin
      cnt_q     <= '0;
      refresh_q <= 1'b0;
    end else if (refresh_q) begin
      cnt_q <= '0;
      if (half_i) refresh_q <= 1'b0;
    end else if (half_i) begin
      if (cnt_q == CW'(LIMIT - 1)) begin
        cnt_q     <= '0;
        refresh_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gate_sequencer.sv
module gate_sequencer
  import gate_ctrl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic pwm_i,
  input  logic armed_i,
  input  logic refresh_i,
  output logic switching_o,
  output logic hs_o,
  output logic ls_o
);
  gate_state_e state_q, state_n;
  logic        hs_q, ls_q, hs_n, ls_n;
  logic        want_hs, want_ls;

  assign want_hs     = pwm_i & ~refresh_i;
  assign want_ls     = ~pwm_i | refresh_i;
  assign switching_o = (state_q == ST_SWITCH);
  assign hs_o        = hs_q;
  assign ls_o        = ls_q;

  always_comb begin
    state_n = state_q;
    hs_n    = 1'b0;
    ls_n    = 1'b0;
    unique case (state_q)
      ST_OFF:    if (armed_i) state_n = ST_PRIME;
      ST_PRIME: begin
        ls_n    = ~hs_q;  // bootstrap charge before any high-side pulse
        state_n = ST_SWITCH;
      end
      ST_SWITCH: begin
        hs_n = want_hs & ~ls_q;  // break-before-make: one clock gap
        ls_n = want_ls & ~hs_q;
      end
      default:   state_n = ST_OFF;
    endcase
    if (!run_i) begin
      state_n = ST_OFF;
      hs_n    = 1'b0;
      ls_n    = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      hs_q    <= 1'b0;
      ls_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      hs_q    <= hs_n;
      ls_q    <= ls_n;
    end
  end
endmodule

// File: rtl/prebias_gate_ctrl.sv
module prebias_gate_ctrl #(
  parameter int unsigned ARM_PULSES      = 2,
  parameter int unsigned REFRESH_PERIODS = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  input  logic run_i,
  input  logic half_i,
  output logic hs_o,
  output logic ls_o
);
  logic armed, refresh, switching;

  gate_arm_qual #(.ARM_PULSES(ARM_PULSES)) u_arm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pwm_i   (pwm_i),
    .run_i   (run_i),
    .armed_o (armed)
  );

  gate_refresh_watch #(.REFRESH_PERIODS(REFRESH_PERIODS)) u_watch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (switching),
    .pwm_i     (pwm_i),
    .half_i    (half_i),
    .refresh_o (refresh)
  );

  gate_sequencer u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_i),
    .pwm_i       (pwm_i),
    .armed_i     (armed),
    .refresh_i   (refresh),
    .switching_o (switching),
    .hs_o        (hs_o),
    .ls_o        (ls_o)
  );
endmodule

// File: rtl/gate_ctrl_checker.sv
module gate_ctrl_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic run_i,
  input logic hs_o,
  input logic ls_o
);
  logic ls_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ls_seen <= 1'b0;
    else if (!run_i) ls_seen <= 1'b0;
    else if (ls_o)   ls_seen <= 1'b1;
  end

  a_r4_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_o && ls_o));

  a_r4_hs_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_o) |-> !ls_o && !$past(ls_o));

  a_r4_ls_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_o) |-> !hs_o && !$past(hs_o));

  a_r9_disable_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !hs_o && !ls_o);

  a_r3_ls_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_o) |-> ls_seen);
endmodule

bind prebias_gate_ctrl gate_ctrl_checker u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .run_i  (run_i),
  .hs_o   (hs_o),
  .ls_o   (ls_o)
);

// File: tb/tb_prebias_gate_ctrl.sv
module tb_prebias_gate_ctrl;
  localparam int HALF = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0, pwm_i = 1'b0, run_i = 1'b0, half_i = 1'b0;
  logic hs_o, ls_o;
  int   total = 0, bad = 0, hcnt = 0;

  prebias_gate_ctrl dut (.*);

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    #1;
    hcnt   = (hcnt == HALF - 1) ? 0 : hcnt + 1;
    half_i = (hcnt == 0);
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk_i); #2; end
  endtask

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset;
    chk("R1 hs in reset", hs_o, 0);
    chk("R1 ls in reset", ls_o, 0);
    rst_ni = 1'b1;
    tick(4);
    chk("R1 hs after reset", hs_o, 0);
    chk("R1 ls after reset", ls_o, 0);
  endtask

  task automatic t_arm;
    run_i = 1'b1; tick(3);
    pwm_i = 1'b1; tick(3); pwm_i = 1'b0; tick(4);
    chk("R2 off after one pulse hs", hs_o, 0);
    chk("R2 off after one pulse ls", ls_o, 0);
    pwm_i = 1'b1;
    tick(); chk("R3 e0", {hs_o, ls_o}, 0);
    tick(); chk("R3 e1", {hs_o, ls_o}, 0);
    tick(); chk("R3 e2 ls first", {hs_o, ls_o}, 1);
    tick(); chk("R3 e3 gap", {hs_o, ls_o}, 0);
    tick(); chk("R3 e4 hs", {hs_o, ls_o}, 2);
    pwm_i = 1'b0; tick(3);
    chk("R3 back to ls", {hs_o, ls_o}, 1);
  endtask

  task automatic t_pass(int w);
    int nh = 0, nl = 0;
    pwm_i = 1'b1;
    for (int i = 0; i < w + 5; i++) begin
      if (i == w) pwm_i = 1'b0;
      tick();
      nh += hs_o; nl += !ls_o;
    end
    chk($sformatf("R5 hs width w=%0d", w), nh, w - 1);
    chk($sformatf("R5 ls low w=%0d", w), nl, w + 1);
  endtask

  task automatic t_levels;
    int miss = 0;
    pwm_i = 1'b0;
    for (int i = 0; i < 300; i++) begin tick(); miss += !ls_o; end
    chk("R6 0% ls held", miss, 0);
    pwm_i = 1'b1; tick(2); miss = 0;
    for (int i = 0; i < 400; i++) begin tick(); miss += !hs_o + ls_o; end
    chk("R6 100% hs held", miss, 0);
    pwm_i = 1'b0; tick(4);
  endtask

  task automatic t_refresh;
    int t = 0, w = 0;
    pwm_i = 1'b1; tick();
    while (!ls_o && t < 1500) begin tick(); t++; end
    total++;
    if (t < 1000 || t > 1060) begin
      bad++; $display("FAIL R7 refresh start actual=%0d expected=1000..1060", t);
    end
    while (ls_o && w < 50) begin tick(); w++; end
    total++;
    if (w < 5 || w > 8) begin
      bad++; $display("FAIL R7 refresh width actual=%0d expected=5..8", w);
    end
    tick(2);
    chk("R7 hs resumes", hs_o, 1);
    w = 0;
    for (int i = 0; i < 900; i++) begin tick(); w += ls_o; end
    chk("R8 no refresh after reset by pulse", w, 0);
    pwm_i = 1'b0; tick(4);
  endtask

  task automatic t_dip;
    int n = 0;
    pwm_i = 1'b1;
    for (int i = 0; i < 900; i++) begin tick(); if (i > 3) n += ls_o; end
    pwm_i = 1'b0; tick(2); pwm_i = 1'b1;
    for (int i = 0; i < 900; i++) begin tick(); if (i > 3) n += ls_o; end
    chk("R8 dip clears count", n, 0);
  endtask

  task automatic t_disable;
    chk("R9 hs on before", hs_o, 1);
    run_i = 1'b0; tick();
    chk("R9 off at once", {hs_o, ls_o}, 0);
    for (int i = 0; i < 3; i++) begin
      pwm_i = 1'b0; tick(2); pwm_i = 1'b1; tick(2);
    end
    chk("R9 stays off", {hs_o, ls_o}, 0);
    pwm_i = 1'b0; tick(2);
  endtask

  task automatic t_restart;
    run_i = 1'b1; tick(2);
    pwm_i = 1'b1; tick(3); pwm_i = 1'b0; tick(5);
    chk("R10 one fresh pulse not enough", {hs_o, ls_o}, 0);
    pwm_i = 1'b1; tick(3);
    chk("R10 armed ls", {hs_o, ls_o}, 1);
    pwm_i = 1'b0; tick(3);
  endtask

  initial begin
    tick(3);
    t_reset();
    t_arm();
    t_pass(2);
    t_pass(5);
    t_pass(10);
    t_levels();
    t_refresh();
    t_dip();
    t_disable();
    t_restart();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule